// File: doc/BRIEF.md
# Net Address Command Processor

This block is the addressing stage of a single-wire slave. After each bus reset and presence pulse it takes the first byte the host writes, which is an opcode. It then either reads out, compares or searches on the device's fixed 64-bit identity, or it selects the device with no address transfer. When addressing succeeds, it raises a held `selected` flag and a one-cycle `handoff` pulse so that the function layer takes over the bus.

A separate bit engine handles the line timing. Once per time slot it gives a one-cycle strobe (`slot_stb`) with the bit the host wrote (`slot_rx`). When this block wants to answer in a slot, it holds `tx_drive` high and `tx_bit` steady before that strobe arrives. The engine then turns the slot into a read slot.

The identity is an input. Its low byte is the family code 09h, the next 48 bits are the serial number, and its top byte is a CRC over the lower 56 bits. That CRC is computed outside the block.

Top module: `netaddr_fsm`

## Requirements
- R1: After `rst_n` low, or a cycle with `bus_reset` high, `selected`, `handoff` and `tx_drive` are 0 and the block waits for an opcode.
- R2: The opcode is taken from the first 8 host-written slots, least significant bit first. No action is taken before the 8th slot.
- R3: Opcode 33h or 39h makes the block drive the 64 identity bits, bit 0 first, one per slot. After the 64th slot, `selected` is 1.
- R4: Opcode 55h makes the block compare the next 64 host-written bits with the identity, bit 0 first. If all 64 are equal, `selected` is 1. On the first unequal bit, the block neither drives nor selects until the next reset.
- R5: Opcode CCh sets `selected` right after the opcode slot, with no address transfer.
- R6: Opcode F0h runs 64 rounds. In each round the block drives identity bit i, then drives its complement, then reads the host's chosen bit. `tx_drive` is high only in the first two slots of each round.
- R7: During a search, if the host's chosen bit differs from identity bit i, the block drops out. It drives nothing and never selects until the next reset.
- R8: A search that completes all 64 rounds without dropping out sets `selected`.
- R9: Any opcode other than 33h, 39h, 55h, CCh or F0h leaves the block idle. It does not drive and does not select until the next reset.
- R10: `handoff` is high for exactly one cycle, in the first cycle that `selected` is 1. `selected` then stays 1 until a reset.
- R11: `bus_reset` returns the block to waiting for an opcode from any state, including in the middle of a transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_reset | input | 1 | Bus reset and presence seen; restart at opcode |
| ident | input | 64 | Device identity, bit 0 sent first |
| slot_stb | input | 1 | One-cycle strobe marking a completed time slot |
| slot_rx | input | 1 | Bit written by the host in the strobed slot |
| tx_drive | output | 1 | Block answers in the next slot |
| tx_bit | output | 1 | Bit to answer with when `tx_drive` is 1 |
| selected | output | 1 | Addressing succeeded; function layer enabled |
| handoff | output | 1 | One-cycle pulse when `selected` rises |

## Verification
Most internal faults show up at the ports within one slot. A wrong bit index puts a wrong identity bit on `tx_bit` in the first read or search slot that uses it. A state that fails to drop out keeps `tx_drive` high in the slot after the host's mismatching bit, or raises `selected` at the end. A wrong opcode decode shows on the 9th slot, as an unexpected `tx_drive` or a missing `selected`.

The bench builds identities with a correct check byte from random serial numbers. It reads them back, matches and searches them both intact and with a bit flipped at a random position, and checks reset in mid-transfer.

// File: rtl/netaddr_fsm.sv
module netaddr_fsm #(
  parameter int ID_W = 64,
  parameter logic [7:0] OP_READ = 8'h33,
  parameter logic [7:0] OP_READ_ALT = 8'h39,
  parameter logic [7:0] OP_MATCH = 8'h55,
  parameter logic [7:0] OP_SKIP = 8'hCC,
  parameter logic [7:0] OP_SEARCH = 8'hF0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bus_reset,
  input  logic [ID_W-1:0] ident,
  input  logic            slot_stb,
  input  logic            slot_rx,
  output logic            tx_drive,
  output logic            tx_bit,
  output logic            selected,
  output logic            handoff
);
  localparam int IDX_W = $clog2(ID_W);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(ID_W - 1);

  typedef enum logic [2:0] {
    S_OPC, S_READ, S_MATCH, S_SB, S_SC, S_SW, S_SEL, S_DEAD
  } st_t;

  st_t st, st_n;
  logic [IDX_W-1:0] idx, idx_n;
  logic [2:0] ocnt;
  logic [7:0] osh;
  logic [7:0] opc;
  logic own;

  assign opc = {slot_rx, osh[7:1]};
  assign own = ident[idx];
  assign selected = (st == S_SEL);
  assign tx_drive = (st == S_READ) || (st == S_SB) || (st == S_SC);
  assign tx_bit = (st == S_SC) ? ~own : own;

  always_comb begin
    st_n = st;
    idx_n = idx;
    if (bus_reset) begin
      st_n = S_OPC;
      idx_n = '0;
    end else if (slot_stb) begin
      unique case (st)
        S_OPC: if (ocnt == 3'd7) begin
          idx_n = '0;
          if (opc == OP_READ || opc == OP_READ_ALT) st_n = S_READ;
          else if (opc == OP_MATCH) st_n = S_MATCH;
          else if (opc == OP_SKIP) st_n = S_SEL;
          else if (opc == OP_SEARCH) st_n = S_SB;
          else st_n = S_DEAD;
        end
        S_READ: if (idx == LAST) st_n = S_SEL; else idx_n = idx + 1'b1;
        S_MATCH:
          if (slot_rx != own) st_n = S_DEAD;
          else if (idx == LAST) st_n = S_SEL;
          else idx_n = idx + 1'b1;
        S_SB: st_n = S_SC;
        S_SC: st_n = S_SW;
        S_SW:
          if (slot_rx != own) st_n = S_DEAD;
          else if (idx == LAST) st_n = S_SEL;
          else begin
            idx_n = idx + 1'b1;
            st_n = S_SB;
          end
        default: st_n = st;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_OPC;
      idx <= '0;
      ocnt <= '0;
      osh <= '0;
      handoff <= 1'b0;
    end else begin
      st <= st_n;
      idx <= idx_n;
      handoff <= (st_n == S_SEL) && (st != S_SEL);
      if (bus_reset) begin
        ocnt <= '0;
        osh <= '0;
      end else if (slot_stb && st == S_OPC) begin
        ocnt <= ocnt + 1'b1;
        osh <= opc;
      end
    end
  end

  a_r10_handoff_single: assert property (@(posedge clk) disable iff (!rst_n)
    handoff |=> !handoff);
  a_r10_rise_has_handoff: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(selected) |-> handoff);
  a_r10_selected_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (selected && !bus_reset) |=> selected);
  a_r1_bus_reset_clears: assert property (@(posedge clk) disable iff (!rst_n)
    bus_reset |=> (!selected && !tx_drive && !handoff));
  a_r6_complement_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_SC && $past(st == S_SB) && $stable(ident)) |-> (tx_bit != $past(tx_bit)));
  a_r7_dead_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_DEAD && !bus_reset) |=> (!tx_drive && !selected));
  a_r2_no_drive_in_opcode: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_OPC) |-> !tx_drive);
endmodule

// File: tb/netaddr_fsm_bench.sv
module netaddr_fsm_bench;
  logic clk = 0, rst_n = 0, bus_reset = 0, slot_stb = 0, slot_rx = 0;
  logic [63:0] ident = '0;
  logic tx_drive, tx_bit, selected, handoff;
  int checks = 0, fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  netaddr_fsm u_netaddr_fsm (
    .clk(clk), .rst_n(rst_n), .bus_reset(bus_reset), .ident(ident),
    .slot_stb(slot_stb), .slot_rx(slot_rx), .tx_drive(tx_drive),
    .tx_bit(tx_bit), .selected(selected), .handoff(handoff));

  function automatic logic [7:0] crc8(input logic [55:0] d);
    logic [7:0] c = '0;
    for (int i = 0; i < 56; i++) begin
      logic fb = c[0] ^ d[i];
      c = c >> 1;
      if (fb) c ^= 8'h8C;
    end
    return c;
  endfunction

  function automatic logic [63:0] make_id();
    logic [47:0] sn = {16'($urandom), 32'($urandom)};
    logic [55:0] lo = {sn, 8'h09};
    return {crc8(lo), lo};
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wslot(input logic b);
    @(negedge clk); slot_stb = 1; slot_rx = b;
    @(posedge clk); @(negedge clk); slot_stb = 0;
  endtask

  task automatic rslot(output logic drv, output logic b);
    @(negedge clk); drv = tx_drive; b = tx_bit; slot_stb = 1; slot_rx = 1;
    @(posedge clk); @(negedge clk); slot_stb = 0;
  endtask

  task automatic wbyte(input logic [7:0] v);
    for (int i = 0; i < 8; i++) wslot(v[i]);
  endtask

  task automatic breset();
    @(negedge clk); bus_reset = 1;
    @(posedge clk); @(negedge clk); bus_reset = 0;
  endtask

  task automatic chk_sel(input string req);
    chk(req, {selected, handoff}, 2'b11);
    @(negedge clk);
    chk("R10 handoff one cycle", {selected, handoff}, 2'b10);
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic drv, b, c;
    void'($urandom(32'h5EED));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 after rst_n", {selected, handoff, tx_drive}, 3'b000);

    // R2 / R5: skip, nothing before 8th slot
    breset();
    for (int i = 0; i < 7; i++) wslot(8'hCC >> i);
    chk("R2 no action before 8th bit", {selected, tx_drive}, 2'b00);
    wslot(1'b1);
    chk_sel("R5 skip selects");
    chk("R5 no drive when selected", tx_drive, 1'b0);
    breset();
    chk("R1 bus_reset clears", {selected, handoff, tx_drive}, 3'b000);

    for (int it = 0; it < 6; it++) begin
      logic [63:0] got;
      int p;
      ident = make_id();
      // R3 read
      breset();
      wbyte(it[0] ? 8'h39 : 8'h33);
      for (int i = 0; i < 64; i++) begin
        rslot(drv, b);
        got[i] = b;
        if (!drv) chk("R3 drive during read", drv, 1'b1);
      end
      chk("R3 identity read", got, ident);
      chk_sel("R3 select after read");
      // R4 match good
      breset();
      wbyte(8'h55);
      for (int i = 0; i < 64; i++) wslot(ident[i]);
      chk_sel("R4 match selects");
      // R4 match bad
      p = int'($urandom_range(63));
      breset();
      wbyte(8'h55);
      for (int i = 0; i < 64; i++) wslot(i == p ? ~ident[i] : ident[i]);
      chk("R4 mismatch drops", {selected, tx_drive}, 2'b00);
      // R6 / R8 full search
      breset();
      wbyte(8'hF0);
      for (int i = 0; i < 64; i++) begin
        rslot(drv, b);
        if (drv !== 1'b1 || b !== ident[i]) chk("R6 search bit", {drv, b}, {1'b1, ident[i]});
        rslot(drv, c);
        if (drv !== 1'b1 || c !== ~ident[i]) chk("R6 search complement", {drv, c}, {1'b1, ~ident[i]});
        @(negedge clk);
        if (tx_drive) chk("R6 no drive in choice slot", tx_drive, 1'b0);
        wslot(ident[i]);
      end
      chk("R6 search rounds ok", 1'b1, 1'b1);
      chk_sel("R8 search completes");
      // R7 search drop out
      breset();
      wbyte(8'hF0);
      for (int i = 0; i < p; i++) begin
        rslot(drv, b); rslot(drv, c); wslot(ident[i]);
      end
      rslot(drv, b); rslot(drv, c);
      wslot(~ident[p]);
      chk("R7 dropped no drive", tx_drive, 1'b0);
      for (int i = 0; i < 10; i++) wslot(1'b1);
      chk("R7 stays silent", {selected, tx_drive}, 2'b00);
    end

    // R9 unknown opcodes
    for (int k = 0; k < 4; k++) begin
      logic [7:0] op;
      do op = 8'($urandom);
      while (op == 8'h33 || op == 8'h39 || op == 8'h55 || op == 8'hCC || op == 8'hF0);
      breset();
      wbyte(op);
      for (int i = 0; i < 20; i++) wslot(i[0]);
      chk("R9 unknown opcode idle", {selected, tx_drive, handoff}, 3'b000);
    end
    // R2 bit order: 33h sent MSB first is CCh LSB first -> skip
    breset();
    for (int i = 7; i >= 0; i--) wslot(8'h33 >> i);
    chk_sel("R2 lsb-first decode");

    // R11 reset mid-read, then skip
    breset();
    wbyte(8'h33);
    for (int i = 0; i < 10; i++) rslot(drv, b);
    breset();
    chk("R11 reset mid-read", {selected, tx_drive}, 2'b00);
    wbyte(8'hCC);
    chk_sel("R11 fresh opcode after reset");
    // R11 reset mid-search then read bit 0
    breset();
    wbyte(8'hF0);
    rslot(drv, b);
    breset();
    wbyte(8'h33);
    @(negedge clk);
    chk("R11 read restarts at bit 0", {tx_drive, tx_bit}, {1'b1, ident[0]});

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule